// File: doc/BRIEF.md
# Bus-sequencing instruction controller

This block is the control unit of a small 8-bit processor. It keeps a program counter that it drives out as the address of a program store. It takes the 32-bit instruction word that comes back and executes it as a fixed series of single transfers over one shared data bus. Every participant on that bus is commanded by the controller: a bank of general registers with one read-enable bit and one write-strobe bit per register, an arithmetic unit with two operand-capture strobes, a result enable and an opcode, and the controller's own constant driver.

The instruction word carries a 4-bit class in bits [31:28] and a 4-bit subclass in bits [27:24], followed by three byte fields: A in [23:16], B in [15:8] and C in [7:0]. Each instruction starts with one fetch cycle. The fetch is followed by one execute cycle, or by three for arithmetic instructions. Exactly one party drives the bus in any cycle. The register bank, the arithmetic unit and the bus multiplexer are outside the block.

Top module: `bsc_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the program address to 0 and returns the controller to its fetch cycle. In that cycle no read, write, load, result-enable or constant-drive output is active.
- R2: Every instruction begins with a fetch cycle in which all enables and strobes are inactive. The controller captures the word present at the current program address at the end of that cycle.
- R3: Class 0 with subclass 1 is move-immediate and takes one execute cycle. In that cycle the controller drives field B onto the bus with its bus enable high and raises the write strobe of the register named by field A.
- R4: Class 1 is an arithmetic instruction. In its first execute cycle the read enable of the register named by field B is high together with the first-operand load strobe.
- R5: In the second execute cycle of an arithmetic instruction, the read enable of the register named by field C is high together with the second-operand load strobe.
- R6: In the third execute cycle of an arithmetic instruction, the result enable is high, the opcode output equals field A, and the write strobe of the register named by field B is high. The opcode values in use are 0 add, 1 subtract, 2 AND, 3 NAND, 4 OR, 5 XOR and 7 NOT of the first operand.
- R7: Class 2 is a jump and takes one execute cycle. The read enable of the register named by field A is high, and the program address then becomes the value that register placed on the bus.
- R8: After every instruction other than a jump, the program address increases by one, and it wraps from 255 to 0.
- R9: Any other class/subclass combination takes one execute cycle with every enable and strobe inactive, and only advances the program address.
- R10: At most one register read enable and at most one register write strobe are high in any cycle. At most one of {constant drive, result enable, any register read} is active in any cycle.
- R11: A register is selected by the low 4 bits of its byte field. Upper bits of the field are ignored, so a field value of 0x11 selects register 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_addr_o | output | 8 | Program counter, used as program-store address |
| prog_word_i | input | 32 | Instruction word read at prog_addr_o |
| bus_i | input | 8 | Resolved value of the shared data bus |
| bus_o | output | 8 | Constant the controller drives onto the bus |
| bus_oe_o | output | 1 | Controller owns the bus this cycle |
| reg_rd_o | output | 16 | One-hot register read enables |
| reg_wr_o | output | 16 | One-hot register write strobes |
| alu_ld_a_o | output | 1 | First-operand capture strobe |
| alu_ld_b_o | output | 1 | Second-operand capture strobe |
| alu_oe_o | output | 1 | Arithmetic result drives the bus |
| alu_op_o | output | 8 | Arithmetic opcode, valid with alu_oe_o |

## Verification
The bench builds the block with the default widths: an 8-bit bus, an 8-bit program counter and sixteen registers. With these widths the whole 256-word program space is addressable, so a jump into the last four words carries execution across the 255-to-0 wrap. Register fields are written with their upper nibble set, which exercises the low-bit selection. Arithmetic instructions that name the same register twice, and a reset asserted in the middle of an instruction, are also reachable at these sizes.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

   localparam int CLS_W = 4;

   localparam logic [CLS_W-1:0] CLS_MOVE = 4'h0;
   localparam logic [CLS_W-1:0] SUB_MOVE = 4'h1;
   localparam logic [CLS_W-1:0] CLS_ALU  = 4'h1;
   localparam logic [CLS_W-1:0] CLS_JUMP = 4'h2;

   typedef enum logic [1:0] {
      PH_FETCH,
      PH_STEP0,
      PH_STEP1,
      PH_STEP2
   } phase_e;

   typedef enum logic [1:0] {
      OP_NOP,
      OP_MOVE,
      OP_ALU,
      OP_JUMP
   } kind_e;

endpackage

// File: rtl/bsc_decode.sv
module bsc_decode
   import bsc_pkg::*;
#(
   parameter  int DW = 8,
   localparam int IW = 2*CLS_W + 3*DW
)(
   input  logic [IW-1:0] word_i,
   output kind_e         kind_o,
   output logic [DW-1:0] fa_o,
   output logic [DW-1:0] fb_o,
   output logic [DW-1:0] fc_o
);

   logic [CLS_W-1:0] cls;
   logic [CLS_W-1:0] sub;

   assign cls  = word_i[IW-1 -: CLS_W];
   assign sub  = word_i[IW-1-CLS_W -: CLS_W];
   assign fa_o = word_i[3*DW-1 -: DW];
   assign fb_o = word_i[2*DW-1 -: DW];
   assign fc_o = word_i[DW-1:0];

   always_comb begin
      if (cls == CLS_MOVE && sub == SUB_MOVE) kind_o = OP_MOVE;
      else if (cls == CLS_ALU)                kind_o = OP_ALU;
      else if (cls == CLS_JUMP)               kind_o = OP_JUMP;
      else                                    kind_o = OP_NOP;
   end

endmodule

// File: rtl/bsc_onehot.sv
module bsc_onehot #(
   parameter  int N     = 16,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
)(
   input  logic             en_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [N-1:0]     vec_o
);

   for (genvar g = 0; g < N; g++) begin : g_bit
      assign vec_o[g] = en_i && (idx_i == IDX_W'(g));
   end

endmodule

// File: rtl/bsc_pc.sv
module bsc_pc #(
   parameter int AW = 8,
   parameter int DW = 8
)(
   input  logic          clk,
   input  logic          rst,
   input  logic          step_i,
   input  logic          load_i,
   input  logic [DW-1:0] target_i,
   output logic [AW-1:0] pc_o
);

   logic [AW-1:0] tgt;

   if (DW >= AW) begin : g_narrow
      assign tgt = target_i[AW-1:0];
      if (DW > AW) begin : g_drop
         logic unused_hi;
         assign unused_hi = ^target_i[DW-1:AW];
      end
   end else begin : g_widen
      assign tgt = {{(AW-DW){1'b0}}, target_i};
   end

   always_ff @(posedge clk) begin
      if (rst)         pc_o <= '0;
      else if (load_i) pc_o <= tgt;
      else if (step_i) pc_o <= pc_o + 1'b1;
   end

endmodule

// File: rtl/bsc_ctrl.sv
module bsc_ctrl
   import bsc_pkg::*;
#(
   parameter  int DW   = 8,
   parameter  int AW   = 8,
   parameter  int NREG = 16,
   localparam int IW   = 2*CLS_W + 3*DW,
   localparam int RI_W = $clog2(NREG)
)(
   input  logic            clk,
   input  logic            rst,
   output logic [AW-1:0]   prog_addr_o,
   input  logic [IW-1:0]   prog_word_i,
   input  logic [DW-1:0]   bus_i,
   output logic [DW-1:0]   bus_o,
   output logic            bus_oe_o,
   output logic [NREG-1:0] reg_rd_o,
   output logic [NREG-1:0] reg_wr_o,
   output logic            alu_ld_a_o,
   output logic            alu_ld_b_o,
   output logic            alu_oe_o,
   output logic [DW-1:0]   alu_op_o
);

   if (NREG < 2 || NREG > (1 << DW)) begin : g_bad_nreg
      $error("bsc_ctrl: NREG must lie in 2..2**DW");
   end
   if (AW < 1 || DW < 4) begin : g_bad_width
      $error("bsc_ctrl: AW must be positive and DW at least 4");
   end

   phase_e        phase;
   logic [IW-1:0] ir;
   kind_e         kind;
   logic [DW-1:0] fa, fb, fc;

   logic            rd_en, wr_en;
   logic [RI_W-1:0] rd_idx, wr_idx;
   logic            last, pc_step, pc_load;

   bsc_decode #(.DW(DW)) i_decode (
      .word_i (ir),
      .kind_o (kind),
      .fa_o   (fa),
      .fb_o   (fb),
      .fc_o   (fc)
   );

   if (DW > RI_W) begin : g_fc_hi
      logic unused_fc;
      assign unused_fc = ^fc[DW-1:RI_W];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_FETCH;
         ir    <= '0;
      end else begin
         case (phase)
            PH_FETCH: begin
               ir    <= prog_word_i;
               phase <= PH_STEP0;
            end
            PH_STEP0: phase <= (kind == OP_ALU) ? PH_STEP1 : PH_FETCH;
            PH_STEP1: phase <= PH_STEP2;
            default:  phase <= PH_FETCH;
         endcase
      end
   end

   always_comb begin
      rd_en      = 1'b0;
      rd_idx     = '0;
      wr_en      = 1'b0;
      wr_idx     = '0;
      bus_oe_o   = 1'b0;
      bus_o      = '0;
      alu_ld_a_o = 1'b0;
      alu_ld_b_o = 1'b0;
      alu_oe_o   = 1'b0;
      alu_op_o   = '0;
      case (phase)
         PH_STEP0: begin
            case (kind)
               OP_MOVE: begin
                  bus_oe_o = 1'b1;
                  bus_o    = fb;
                  wr_en    = 1'b1;
                  wr_idx   = fa[RI_W-1:0];
               end
               OP_ALU: begin
                  rd_en      = 1'b1;
                  rd_idx     = fb[RI_W-1:0];
                  alu_ld_a_o = 1'b1;
               end
               OP_JUMP: begin
                  rd_en  = 1'b1;
                  rd_idx = fa[RI_W-1:0];
               end
               default: ;
            endcase
         end
         PH_STEP1: begin
            rd_en      = 1'b1;
            rd_idx     = fc[RI_W-1:0];
            alu_ld_b_o = 1'b1;
         end
         PH_STEP2: begin
            alu_oe_o = 1'b1;
            alu_op_o = fa;
            wr_en    = 1'b1;
            wr_idx   = fb[RI_W-1:0];
         end
         default: ;
      endcase
   end

   assign last    = (phase == PH_STEP0 && kind != OP_ALU) || phase == PH_STEP2;
   assign pc_step = last && kind != OP_JUMP;
   assign pc_load = phase == PH_STEP0 && kind == OP_JUMP;

   bsc_onehot #(.N(NREG)) i_rd_sel (
      .en_i  (rd_en),
      .idx_i (rd_idx),
      .vec_o (reg_rd_o)
   );

   bsc_onehot #(.N(NREG)) i_wr_sel (
      .en_i  (wr_en),
      .idx_i (wr_idx),
      .vec_o (reg_wr_o)
   );

   bsc_pc #(.AW(AW), .DW(DW)) i_pc (
      .clk      (clk),
      .rst      (rst),
      .step_i   (pc_step),
      .load_i   (pc_load),
      .target_i (bus_i),
      .pc_o     (prog_addr_o)
   );

endmodule

// File: rtl/bsc_ctrl_chk.sv
module bsc_ctrl_chk #(
   parameter int DW   = 8,
   parameter int AW   = 8,
   parameter int NREG = 16
)(
   input logic            clk,
   input logic            rst,
   input logic [AW-1:0]   prog_addr_o,
   input logic [DW-1:0]   bus_i,
   input logic            bus_oe_o,
   input logic [NREG-1:0] reg_rd_o,
   input logic [NREG-1:0] reg_wr_o,
   input logic            alu_ld_a_o,
   input logic            alu_ld_b_o,
   input logic            alu_oe_o
);

   logic was_rst;
   always_ff @(posedge clk) was_rst <= rst;

   logic idle;
   assign idle = reg_rd_o == '0 && reg_wr_o == '0 && !bus_oe_o &&
                 !alu_oe_o && !alu_ld_a_o && !alu_ld_b_o;

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
      was_rst |-> (prog_addr_o == '0 && idle)); // R1

   AST_FETCH_AFTER_RESULT: assert property (@(posedge clk) disable iff (rst)
      alu_oe_o |=> idle); // R2

   AST_MOVE_HAS_TARGET: assert property (@(posedge clk) disable iff (rst)
      bus_oe_o |-> $countones(reg_wr_o) == 1); // R3

   AST_FIRST_LOAD_READS: assert property (@(posedge clk) disable iff (rst)
      alu_ld_a_o |-> $countones(reg_rd_o) == 1); // R4

   AST_SECOND_LOAD_ORDER: assert property (@(posedge clk) disable iff (rst)
      alu_ld_a_o |=> (alu_ld_b_o && $countones(reg_rd_o) == 1)); // R5

   AST_RESULT_ORDER: assert property (@(posedge clk) disable iff (rst)
      alu_ld_b_o |=> (alu_oe_o && $countones(reg_wr_o) == 1)); // R6

   AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
      (reg_rd_o != '0 && !alu_ld_a_o && !alu_ld_b_o) |=>
         prog_addr_o == AW'($past(bus_i))); // R7

   AST_MOVE_ADVANCES: assert property (@(posedge clk) disable iff (rst)
      bus_oe_o |=> prog_addr_o == AW'($past(prog_addr_o) + 1)); // R8

   AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(reg_rd_o)); // R10

   AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(reg_wr_o)); // R10

   AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
      $countones({bus_oe_o, alu_oe_o, reg_rd_o != '0}) <= 1); // R10

endmodule

bind bsc_ctrl bsc_ctrl_chk #(.DW(DW), .AW(AW), .NREG(NREG)) i_chk (
   .clk         (clk),
   .rst         (rst),
   .prog_addr_o (prog_addr_o),
   .bus_i       (bus_i),
   .bus_oe_o    (bus_oe_o),
   .reg_rd_o    (reg_rd_o),
   .reg_wr_o    (reg_wr_o),
   .alu_ld_a_o  (alu_ld_a_o),
   .alu_ld_b_o  (alu_ld_b_o),
   .alu_oe_o    (alu_oe_o)
);

// File: tb/test_bsc_ctrl.sv
module test_bsc_ctrl;

   localparam int DW    = 8;
   localparam int AW    = 8;
   localparam int NREG  = 16;
   localparam int IW    = 32;
   localparam int DEPTH = 256;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic            rst;
   logic [AW-1:0]   prog_addr;
   logic [IW-1:0]   prog_word;
   logic [DW-1:0]   bus;
   logic [DW-1:0]   bus_o;
   logic            bus_oe;
   logic [NREG-1:0] reg_rd;
   logic [NREG-1:0] reg_wr;
   logic            ld_a, ld_b, alu_oe;
   logic [DW-1:0]   alu_op;

   logic [IW-1:0] prog [DEPTH];
   logic [DW-1:0] bank [NREG];
   logic [DW-1:0] opa, opb;

   int n_chk = 0;
   int n_err = 0;
   bit running = 1'b0;
   bit wrap_seen = 1'b0;
   logic [AW-1:0] prev_addr = '0;

   bsc_ctrl #(.DW(DW), .AW(AW), .NREG(NREG)) i_bsc_ctrl (
      .clk         (clk),
      .rst         (rst),
      .prog_addr_o (prog_addr),
      .prog_word_i (prog_word),
      .bus_i       (bus),
      .bus_o       (bus_o),
      .bus_oe_o    (bus_oe),
      .reg_rd_o    (reg_rd),
      .reg_wr_o    (reg_wr),
      .alu_ld_a_o  (ld_a),
      .alu_ld_b_o  (ld_b),
      .alu_oe_o    (alu_oe),
      .alu_op_o    (alu_op)
   );

   function automatic logic [DW-1:0] alu_calc(logic [DW-1:0] op, logic [DW-1:0] a, logic [DW-1:0] b);
      case (op)
         8'd0: return a + b;
         8'd1: return a - b;
         8'd2: return a & b;
         8'd3: return ~(a & b);
         8'd4: return a | b;
         8'd5: return a ^ b;
         8'd7: return ~a;
         default: return '0;
      endcase
   endfunction

   function automatic int kind_of(logic [IW-1:0] w);
      if (w[31:28] == 4'h0 && w[27:24] == 4'h1) return 1;
      if (w[31:28] == 4'h1) return 2;
      if (w[31:28] == 4'h2) return 3;
      return 0;
   endfunction

   function automatic logic [IW-1:0] enc(int cls, int sub, int a, int b, int c);
      return {cls[3:0], sub[3:0], a[7:0], b[7:0], c[7:0]};
   endfunction

   // program store and shared bus with a single driver multiplexer
   assign prog_word = prog[prog_addr];

   always_comb begin
      bus = '0;
      if (bus_oe)      bus = bus_o;
      else if (alu_oe) bus = alu_calc(alu_op, opa, opb);
      else begin
         for (int i = 0; i < NREG; i++)
            if (reg_rd[i]) bus = bank[i];
      end
   end

   always @(posedge clk) begin
      for (int i = 0; i < NREG; i++) begin
         if (rst)            bank[i] <= '0;
         else if (reg_wr[i]) bank[i] <= bus;
      end
      if (rst) begin
         opa <= '0;
         opb <= '0;
      end else begin
         if (ld_a) opa <= bus;
         if (ld_b) opb <= bus;
      end
   end

   // reference model: instruction phase counter and architectural state
   int            m_ph = 0;
   bit            m_rst = 1'b1;
   logic [AW-1:0] m_pc = '0;
   logic [IW-1:0] m_ir = '0;
   logic [DW-1:0] m_reg [NREG];

   always @(posedge clk) begin
      int k;
      int fa, fb, fc;
      k  = kind_of(m_ir);
      fa = int'(m_ir[23:16]);
      fb = int'(m_ir[15:8]);
      fc = int'(m_ir[7:0]);
      m_rst = rst;
      if (rst) begin
         m_ph = 0;
         m_pc = '0;
         m_ir = '0;
         for (int i = 0; i < NREG; i++) m_reg[i] = '0;
      end else begin
         case (m_ph)
            0: begin
               m_ir = prog[m_pc];
               m_ph = 1;
            end
            1: begin
               if (k == 2) m_ph = 2;
               else begin
                  if (k == 1) m_reg[fa % NREG] = m_ir[15:8];
                  if (k == 3) m_pc = m_reg[fa % NREG];
                  else        m_pc = m_pc + 1'b1;
                  m_ph = 0;
               end
            end
            2: m_ph = 3;
            default: begin
               m_reg[fb % NREG] = alu_calc(m_ir[23:16], m_reg[fb % NREG], m_reg[fc % NREG]);
               m_pc = m_pc + 1'b1;
               m_ph = 0;
            end
         endcase
      end
   end

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (running) begin
         int k;
         int fa, fb, fc, drivers;
         string tag;
         logic [NREG-1:0] e_rd, e_wr;
         logic e_lda, e_ldb, e_oe, e_boe;
         logic [DW-1:0] e_op, e_bus;
         bit regs_ok;
         k  = kind_of(m_ir);
         fa = int'(m_ir[23:16]);
         fb = int'(m_ir[15:8]);
         fc = int'(m_ir[7:0]);
         e_rd = '0; e_wr = '0; e_lda = 0; e_ldb = 0; e_oe = 0; e_boe = 0;
         e_op = '0; e_bus = '0;
         if (m_rst) tag = "R1 reset idle";
         else begin
            case (m_ph)
               0: tag = "R2 fetch idle";
               1: case (k)
                     1: begin tag = "R3 move"; e_boe = 1; e_bus = m_ir[15:8]; e_wr = NREG'(1) << (fa % NREG); end
                     2: begin tag = "R4 alu first operand"; e_rd = NREG'(1) << (fb % NREG); e_lda = 1; end
                     3: begin tag = "R7 jump read"; e_rd = NREG'(1) << (fa % NREG); end
                     default: tag = "R9 no-op";
                  endcase
               2: begin tag = "R5 alu second operand"; e_rd = NREG'(1) << (fc % NREG); e_ldb = 1; end
               default: begin
                  tag = "R6 alu result"; e_oe = 1; e_op = m_ir[23:16];
                  e_wr = NREG'(1) << (fb % NREG);
               end
            endcase
         end
         chk(tag, 64'({reg_rd, reg_wr, ld_a, ld_b, alu_oe, alu_op, bus_oe, bus_oe ? bus_o : 8'h00}),
                  64'({e_rd, e_wr, e_lda, e_ldb, e_oe, e_op, e_boe, e_bus}));
         chk(m_rst ? "R1 reset address" : "R8 program address", 64'(prog_addr), 64'(m_pc));
         drivers = int'(bus_oe) + int'(alu_oe) + $countones(reg_rd);
         n_chk++;
         if (drivers > 1 || $countones(reg_wr) > 1) begin
            n_err++;
            $display("FAIL R10 bus drivers: actual=%0d expected<=1", drivers);
         end
         if (m_ph == 0) begin
            regs_ok = 1'b1;
            for (int i = 0; i < NREG; i++) if (bank[i] !== m_reg[i]) regs_ok = 1'b0;
            if (!regs_ok) begin
               for (int i = 0; i < NREG; i++)
                  if (bank[i] !== m_reg[i])
                     $display("FAIL R11 register %0d contents: actual=%h expected=%h", i, bank[i], m_reg[i]);
            end
            n_chk++;
            if (!regs_ok) n_err++;
         end
         if (!m_rst && prev_addr == 8'hFF && prog_addr == 8'h00) wrap_seen = 1'b1;
         prev_addr = prog_addr;
      end
   end

   initial begin
      #(20 * 5000);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      rst = 1'b1;
      for (int i = 0; i < DEPTH; i++) prog[i] = '0;
      prog[0]    = enc(0, 1, 8'h00, 8'h0A, 0);
      prog[1]    = enc(0, 1, 8'h11, 8'h07, 0);   // R11 upper nibble ignored
      prog[2]    = enc(1, 0, 0, 8'h00, 8'h01);   // add
      prog[3]    = enc(0, 1, 8'h02, 8'hF0, 0);
      prog[4]    = enc(0, 1, 8'h03, 8'h3C, 0);
      prog[5]    = enc(1, 0, 1, 8'h02, 8'h03);   // subtract
      prog[6]    = enc(1, 0, 2, 8'h03, 8'h02);   // and
      prog[7]    = enc(1, 0, 3, 8'h00, 8'h01);   // nand
      prog[8]    = enc(1, 0, 4, 8'h01, 8'h03);   // or
      prog[9]    = enc(1, 0, 5, 8'h02, 8'h01);   // xor
      prog[10]   = enc(1, 0, 7, 8'h23, 8'h00);   // not, field with high bits
      prog[11]   = enc(3, 0, 8'hFF, 8'hFF, 8'hFF); // undefined class
      prog[12]   = enc(0, 5, 8'h04, 8'h55, 0);   // undefined subclass
      prog[13]   = enc(0, 1, 8'h06, 8'h81, 0);
      prog[14]   = enc(1, 0, 0, 8'h06, 8'h06);   // same register twice
      prog[15]   = enc(0, 1, 8'h1F, 8'hFC, 0);
      prog[16]   = enc(2, 0, 8'h0F, 0, 0);       // jump to 0xFC
      prog[8'hFC] = enc(0, 1, 8'h07, 8'h99, 0);
      prog[8'hFD] = enc(1, 0, 5, 8'h07, 8'h00);
      prog[8'hFE] = enc(4, 2, 0, 0, 0);
      prog[8'hFF] = enc(0, 1, 8'h08, 8'h42, 0);
      @(negedge clk);
      running = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      repeat (400) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 reset mid-run address", 64'(prog_addr), 64'd0);
      rst = 1'b0;
      repeat (7) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      repeat (200) @(negedge clk);
      n_chk++;
      if (!wrap_seen) begin
         n_err++;
         $display("FAIL R8 wrap: actual=not seen expected=255 to 0");
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule